// File: doc/BRIEF.md
# Edge Change-Detection Interrupt Controller

This block watches a bank of digital input lines, grouped into 8-bit ports, for rising and falling transitions. The input lines are first passed through a two-stage synchronizer. A transition counts only when three conditions hold: the line's own rising or falling mask bit is set, the matching global polarity gate in the control byte is on, and edge detection is enabled. When an edge counts, the block latches an edge-pending flag and records which polarity fired. A second edge that arrives while the first is still unacknowledged can also raise an overflow flag.

Software reaches the block through a byte-wide register bus. Writes take effect on the clock edge and reads are combinational. Software reads a status byte and acknowledges causes by writing ones to a clear byte. The interrupt output is a level: it stays high until software clears the cause or turns off interrupt generation.

Register map (byte addresses):
- 0x00: control.
- 0x01: status, read only.
- 0x02: clear, write-one-to-clear; reads as zero.
- 0x10 + 2p: rising mask for port p.
- 0x11 + 2p: falling mask for port p.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the control byte, the status byte, every mask byte and `irq` are all zero.
- R2: Rising edges are detected when the control byte has bit 0 (detect enable) and bit 3 (rise gate) set. A 0-to-1 change on a line whose rising mask bit is 1 then sets status bit 0 (edge pending) and status bit 3 (rise seen). Both are visible within four clock cycles of the input change.
- R3: Falling edges are detected when control bit 0 and bit 4 (fall gate) are set. A 1-to-0 change on a line whose falling mask bit is 1 then sets status bit 0 and status bit 4 (fall seen).
- R4: A transition on a line whose mask bit for that polarity is 0 sets no status bit.
- R5: While the rise gate (control bit 3) is clear, rising edges are ignored even on masked-in lines. The same holds for falling edges while the fall gate (control bit 4) is clear.
- R6: With control bit 1 (overflow enable) set, an enabled edge that arrives while status bit 0 is already set also sets status bit 1 (overflow). With control bit 1 clear, no overflow is recorded.
- R7: Status bit 2 (summary) and the `irq` output both equal control bit 2 (interrupt enable) AND (status bit 0 OR status bit 1). Both stay high until the cause is cleared.
- R8: The clear byte works write-one-to-clear:
  - Writing bit 3 clears status bits 0, 3 and 4.
  - Writing bit 2 clears status bit 1.
  - Writing zeros changes nothing.
- R9: Writing zero to the control byte stops all new detection and drops `irq` and the summary bit. Causes that were already latched stay in status bits 0, 3 and 4.
- R10: The mask bytes and the control byte read back as written. Mask bit b of port p governs input line 8p+b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| lines_in | input | NUM_PORTS*8 | Asynchronous digital input lines |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that:
- the interrupt stays at its level while nothing clears it;
- overflow never rises without an already pending edge;
- a polarity flag never exists without the edge flag;
- the edge flag rises only when detection was enabled and falls only on a clear write.

Only the bench scenarios can show the rest: that the right polarity is reported for each mask and gate combination, that mask addressing maps to the right lines, and that the latency from an input change to status is bounded.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [NUM_PORTS*8-1:0] lines_in,
  output logic                   irq
);
  localparam int NLINES = NUM_PORTS * 8;
  localparam logic [ADDR_W-1:0] CTRL_A = 'h00;
  localparam logic [ADDR_W-1:0] STAT_A = 'h01;
  localparam logic [ADDR_W-1:0] CLR_A  = 'h02;
  localparam int MASK_BASE = 'h10;

  logic [4:0] ctrl_q;
  logic [NLINES-1:0] sync1, sync2, prev_q;
  logic [NLINES-1:0] rise_mask, fall_mask;
  logic edge_pend, ovf_pend, rise_seen, fall_seen;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rise_mask[p*8 +: 8] <= '0;
        fall_mask[p*8 +: 8] <= '0;
      end else if (wr_en) begin
        if (int'(addr) == MASK_BASE + 2*p)     rise_mask[p*8 +: 8] <= wdata;
        if (int'(addr) == MASK_BASE + 2*p + 1) fall_mask[p*8 +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev_q <= '0;
    end else begin
      sync1  <= lines_in;
      sync2  <= sync1;
      prev_q <= sync2;
    end
  end

  wire [NLINES-1:0] rise_hit = sync2 & ~prev_q & rise_mask & {NLINES{ctrl_q[3]}};
  wire [NLINES-1:0] fall_hit = ~sync2 & prev_q & fall_mask & {NLINES{ctrl_q[4]}};
  wire rise_any = ctrl_q[0] & (|rise_hit);
  wire fall_any = ctrl_q[0] & (|fall_hit);
  wire edge_any = rise_any | fall_any;
  wire clr_wr   = wr_en && (addr == CLR_A);
  wire edge_clr = clr_wr & wdata[3];
  wire ovf_clr  = clr_wr & wdata[2];
  wire summary  = ctrl_q[2] & (edge_pend | ovf_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      edge_pend <= 1'b0;
      ovf_pend  <= 1'b0;
      rise_seen <= 1'b0;
      fall_seen <= 1'b0;
    end else begin
      if (wr_en && addr == CTRL_A) ctrl_q <= wdata[4:0];
      if (edge_any)      edge_pend <= 1'b1;
      else if (edge_clr) edge_pend <= 1'b0;
      if (rise_any)      rise_seen <= 1'b1;
      else if (edge_clr) rise_seen <= 1'b0;
      if (fall_any)      fall_seen <= 1'b1;
      else if (edge_clr) fall_seen <= 1'b0;
      if (edge_any && edge_pend && ctrl_q[1]) ovf_pend <= 1'b1;
      else if (ovf_clr)                       ovf_pend <= 1'b0;
    end
  end

  assign irq = summary;

  always_comb begin
    rdata = 8'h00;
    if (addr == CTRL_A) rdata = {3'b000, ctrl_q};
    if (addr == STAT_A) rdata = {3'b000, fall_seen, rise_seen, summary, ovf_pend, edge_pend};
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(addr) == MASK_BASE + 2*p)     rdata = rise_mask[p*8 +: 8];
      if (int'(addr) == MASK_BASE + 2*p + 1) rdata = fall_mask[p*8 +: 8];
    end
  end
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              irq,
  input logic [4:0]        ctrl_q,
  input logic              edge_pend,
  input logic              ovf_pend,
  input logic              rise_seen,
  input logic              fall_seen
);
  wire clr_write  = wr_en && addr == 'h02;
  wire ctrl_write = wr_en && addr == 'h00;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_write && !ctrl_write) |=> irq); // R7
  AST_OVF_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_pend) |-> $past(edge_pend) && $past(ctrl_q[1])); // R6
  AST_FLAG_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_seen || fall_seen) |-> edge_pend); // R2
  AST_EDGE_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_pend) |-> $past(clr_write && wdata[3])); // R8
  AST_DETECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_pend) |-> $past(ctrl_q[0])); // R9
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .ctrl_q(ctrl_q), .edge_pend(edge_pend), .ovf_pend(ovf_pend),
  .rise_seen(rise_seen), .fall_seen(fall_seen)
);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;
  localparam int NP = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [NP*8-1:0] lines = '0;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_irq_ctrl #(.NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lines_in(lines), .irq(irq)
  );

  // {ctrl, rise mask p0, fall mask p0, lines before, lines after, expected status}
  localparam logic [47:0] VEC [7] = '{
    {8'h0D, 8'h01, 8'h00, 8'h00, 8'h01, 8'h0D}, // R2
    {8'h15, 8'h00, 8'h80, 8'h80, 8'h00, 8'h15}, // R3
    {8'h1D, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00}, // R4
    {8'h15, 8'hFF, 8'hFF, 8'h00, 8'hF0, 8'h00}, // R5
    {8'h19, 8'h0F, 8'h0F, 8'h05, 8'h0A, 8'h19}, // R7 no int enable
    {8'h1C, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00}, // R9
    {8'h1F, 8'h10, 8'h20, 8'h20, 8'h10, 8'h1D}  // R2 R3 together
  };
  localparam string VREQ [7] = '{"R2", "R3", "R4", "R5", "R7", "R9", "R3"};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h01, v); chk("R1 status", v, 8'h00);
    rd(8'h00, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h12, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 7; i++) begin
      wr(8'h00, 8'h00);
      @(negedge clk); lines[7:0] = VEC[i][23:16];
      settle();
      wr(8'h02, 8'h0C);
      wr(8'h10, VEC[i][39:32]);
      wr(8'h11, VEC[i][31:24]);
      wr(8'h00, VEC[i][47:40]);
      @(negedge clk); lines[7:0] = VEC[i][15:8];
      settle();
      rd(8'h01, v); chk(VREQ[i], v, VEC[i][7:0]);
      chk({VREQ[i], " R7 irq"}, {7'b0, irq}, {7'b0, VEC[i][2]});
    end

    // R10 readback and port addressing
    wr(8'h00, 8'h00); lines = '0; settle();
    wr(8'h02, 8'h0C);
    wr(8'h10, 8'h00); wr(8'h11, 8'h00);
    wr(8'h14, 8'hA5); wr(8'h17, 8'h3C);
    rd(8'h14, v); chk("R10 rise mask p2", v, 8'hA5);
    rd(8'h17, v); chk("R10 fall mask p3", v, 8'h3C);
    wr(8'h00, 8'h0D);
    rd(8'h00, v); chk("R10 ctrl", v, 8'h0D);
    @(negedge clk); lines[17] = 1'b1; settle();
    rd(8'h01, v); chk("R10 unmasked p2 line", v, 8'h00);
    @(negedge clk); lines[16] = 1'b1; settle();
    rd(8'h01, v); chk("R10 p2 line0", v, 8'h0D);
    wr(8'h00, 8'h00); wr(8'h14, 8'h00); wr(8'h17, 8'h00);
    lines = '0; settle();

    // R6 overflow and R8 clears
    wr(8'h02, 8'h0C); wr(8'h10, 8'h03); wr(8'h00, 8'h0F);
    @(negedge clk); lines[0] = 1'b1; settle();
    rd(8'h01, v); chk("R6 first edge", v, 8'h0D);
    @(negedge clk); lines[1] = 1'b1; settle();
    rd(8'h01, v); chk("R6 overflow", v, 8'h0F);
    wr(8'h02, 8'h00);
    rd(8'h01, v); chk("R8 zero write", v, 8'h0F);
    wr(8'h02, 8'h04);
    rd(8'h01, v); chk("R8 overflow clear", v, 8'h0D);
    wr(8'h02, 8'h08);
    rd(8'h01, v); chk("R8 edge clear", v, 8'h00);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
    wr(8'h00, 8'h00); lines = '0; settle();
    wr(8'h02, 8'h0C); wr(8'h00, 8'h0D);
    @(negedge clk); lines[0] = 1'b1; settle();
    @(negedge clk); lines[1] = 1'b1; settle();
    rd(8'h01, v); chk("R6 overflow disabled", v, 8'h0D);

    // R7 hold, R9 control zero
    repeat (20) @(negedge clk);
    chk("R7 irq held", {7'b0, irq}, 8'h01);
    wr(8'h00, 8'h00);
    chk("R9 irq dropped", {7'b0, irq}, 8'h00);
    rd(8'h01, v); chk("R9 latched kept", v, 8'h09);
    wr(8'h02, 8'h0C);
    @(negedge clk); lines[1:0] = 2'b00; settle();
    @(negedge clk); lines[1:0] = 2'b11; settle();
    rd(8'h01, v); chk("R9 no detection", v, 8'h00);

    finish_run();
  end
endmodule